// File: doc/BRIEF.md
# Serial Control Register Port with Audio-Clock Resynchronisation

This block receives configuration words for a stereo audio converter over three wires: a data line, a shift clock and a latch strobe. Each word is sixteen bits long and arrives most significant bit first. On the latch strobe, the upper seven bits select one of four setting registers. The lower nine bits are written into the selected register. The registers hold the two channel volume codes, the converter settings and the serial-format settings. The audio path reads all of them.

The control side runs on its own local clock, `cclk`. It oversamples the three wires, so the shift clock never acts as a clock inside the block. After every accepted write, the full set of settings is copied as one snapshot into the audio clock domain, `aclk`. The copy uses a request/acknowledge toggle pair. The audio side takes a snapshot only once the request has passed through a synchroniser.

Volume codes use a two-stage scheme. A write first lands in a pre-latch. Both channels are moved to the outputs only when a write carries the update flag. The outputs then change together with a one-cycle pulse on the audio side. Writing the power-down bit returns every other setting to its reset value.

Top module: `ctl3w_top`

## Requirements
- R1: After reset, `att_l` and `att_r` are 0xFF, `dac_cfg` and `ifc_cfg` are 0, and `att_upd` is low.
- R2: A frame is the last 16 values of `ser_dat` taken at rising edges of `ser_clk`, first bit in becoming bit 15. Bits 15:9 are the register address and bits 8:0 the data. The frame is committed on a rising edge of `ser_latch`.
- R3: A latch edge after fewer than 16 shift edges since the previous latch edge (or reset) changes nothing. When more than 16 bits were shifted, only the last 16 count.
- R4: A frame whose address is above 3 changes no setting.
- R5: Address 0 (left) and address 1 (right) load data bits 7:0 into a pre-latch. With data bit 8 at 0, `att_l` and `att_r` do not change.
- R6: A write to address 0 or 1 with data bit 8 at 1 moves both pre-latched codes to `att_l`/`att_r` at once. In the same `aclk` cycle, `att_upd` pulses high for exactly one cycle.
- R7: Address 2 loads data bits 5:0 into `dac_cfg`: bit 0 mute, bit 1 de-emphasis, bit 2 power-down, bits 5:3 word-format code. Data bits 8:6 are dropped.
- R8: Address 3 loads data bits 8:0 into `ifc_cfg` with bit 3 forced to 0. The bits are: bit 0 I2S format, bit 1 word-clock polarity, bit 2 attenuation tie, bit 4 phase reverse, bit 5 bit-clock polarity, bits 7:6 de-emphasis rate, bit 8 zero-detect enable.
- R9: A write to address 2 with data bit 2 at 1 gives `dac_cfg` = 0x04. It also restores both pre-latched and applied volume codes to 0xFF (with an `att_upd` pulse) and clears `ifc_cfg`.
- R10: The audio-side outputs change only when a complete snapshot is taken. Writes made while a transfer is in flight are merged, and the outputs settle to the state of the last write, including any pending update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Control-side clock that oversamples the serial wires |
| crst_n | input | 1 | Active-low reset, control side |
| ser_clk | input | 1 | Serial shift clock (sampled, not used as a clock) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe; a rising edge commits the frame |
| aclk | input | 1 | Audio-domain clock |
| arst_n | input | 1 | Active-low reset, audio side |
| att_l | output | 8 | Applied left volume code |
| att_r | output | 8 | Applied right volume code |
| att_upd | output | 1 | One-cycle pulse when the volume codes are applied |
| dac_cfg | output | 6 | Converter settings (mute, de-emphasis, power-down, format code) |
| ifc_cfg | output | 9 | Serial-format and output settings, bit 3 always 0 |

## Verification
The hardest case to reach from the ports is a set of writes that arrive while an earlier snapshot is still crossing into the audio domain. With normal clock ratios, a serial frame takes far longer than a handshake round trip. The bench therefore slows `aclk` by two orders of magnitude for one sequence. In that window it sends a volume write with update, a pre-latch write, a second update and a settings write back to back. It then checks that the outputs settle to the merged final state with no more than two update pulses. Frames that are too short or too long are also driven, to check how the frame boundary is aligned.

// File: rtl/ctl3w_pkg.sv
// Package: shared widths, register addresses and the snapshot type that
// crosses from the control clock domain into the audio clock domain.
package ctl3w_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = FRAME_W - ADDR_W;
    localparam int ATT_W    = 8;
    localparam int DAC_W    = 6;
    localparam int IFC_W    = 9;
    localparam int NUM_REGS = 4;
    localparam int NUM_CH   = 2;

    // Register addresses; the channel order (left first) is relied on.
    localparam int A_LEFT  = 0;
    localparam int A_RIGHT = 1;
    localparam int A_DAC   = 2;
    localparam int A_IFC   = 3;

    // Bit positions inside the data field.
    localparam int UPD_BIT      = 8;
    localparam int PWDN_BIT     = 2;
    localparam int IFC_RSVD_BIT = 3;

    localparam logic [ATT_W-1:0] ATT_RESET = '1;

    typedef struct packed {
        logic [ATT_W-1:0] att_l;
        logic [ATT_W-1:0] att_r;
        logic [DAC_W-1:0] dac;
        logic [IFC_W-1:0] ifc;
        logic             upd_tgl;
    } cfg_snap_t;
endpackage

// File: rtl/ctl3w_sync.sv
// Multi-flop synchroniser for a bus of independent single-bit signals.
// Assumes each bit is either quasi-static or a level whose individual
// transitions may be seen one cycle apart from its neighbours.
module ctl3w_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Shift the input through STAGES flop rows.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/ctl3w_shift.sv
// Serial frame receiver on the control clock. It oversamples the shift
// clock, data and latch wires, shifts data on shift-clock rising edges and
// emits a one-cycle frame_vld on a latch rising edge only if at least
// FRAME_W bits arrived since the previous latch. Assumes the wires are held
// for at least two cclk periods between changes.
module ctl3w_shift
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_latch,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [2:0]         wires_s;
    logic               clk_s, dat_s, lat_s;
    logic               clk_p, lat_p;
    logic               clk_rise, lat_rise;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_wsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_dat, ser_latch}),
        .q     (wires_s)
    );

    assign {clk_s, dat_s, lat_s} = wires_s;
    assign clk_rise = clk_s & ~clk_p;
    assign lat_rise = lat_s & ~lat_p;

    // Previous-value flops for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_p <= 1'b0;
            lat_p <= 1'b0;
        end else begin
            clk_p <= clk_s;
            lat_p <= lat_s;
        end
    end

    // Shift register and saturating bit counter; the latch edge has priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (lat_rise) begin
            cnt   <= '0;
        end else if (clk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], dat_s};
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
        end
    end

    // Frame hand-off to the register file.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= lat_rise && (cnt == CNT_FULL);
            if (lat_rise) frame <= shreg;
        end
    end
endmodule

// File: rtl/ctl3w_regs.sv
// Control-domain register file and snapshot launcher. It decodes committed
// frames into the volume pre-latches and the two settings registers, applies
// the power-down clear, and launches a full snapshot toward the audio domain
// whenever something changed and no transfer is outstanding. Update requests
// made during a transfer are merged into the next launch.
module ctl3w_regs
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame,
    input  logic               ack_s,
    output cfg_snap_t          shadow,
    output cfg_snap_t          snap,
    output logic               req_tgl
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] ADDR_DAC  = ADDR_W'(A_DAC);
    localparam logic [ADDR_W-1:0] ADDR_IFC  = ADDR_W'(A_IFC);
    localparam logic [ADDR_W-1:0] ADDR_R    = ADDR_W'(A_RIGHT);
    localparam logic [DAC_W-1:0]  DAC_PWDN  = DAC_W'(1) << PWDN_BIT;
    localparam logic [IFC_W-1:0]  IFC_MASK  = ~(IFC_W'(1) << IFC_RSVD_BIT);

    logic [ADDR_W-1:0]              addr;
    logic [DATA_W-1:0]              data;
    logic                           wr, pwdn_wr, upd_req, busy, launch;
    logic [NUM_CH-1:0][ATT_W-1:0]   pre_att;
    logic [DAC_W-1:0]               dac_r;
    logic [IFC_W-1:0]               ifc_r;
    logic                           dirty, upd_pend;

    assign addr    = frame[FRAME_W-1 -: ADDR_W];
    assign data    = frame[DATA_W-1:0];
    assign wr      = frame_vld && (addr <= ADDR_LAST);
    assign pwdn_wr = wr && (addr == ADDR_DAC) && data[PWDN_BIT];
    assign upd_req = (wr && (addr <= ADDR_R) && data[UPD_BIT]) || pwdn_wr;
    assign busy    = (req_tgl != ack_s);
    assign launch  = dirty && !busy;

    // One volume pre-latch per channel, address equal to channel index.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [ATT_W-1:0] q;
        // Load the pre-latch on its own address; power-down restores it.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q <= ATT_RESET;
            else if (pwdn_wr)                         q <= ATT_RESET;
            else if (wr && (addr == ADDR_W'(ch)))     q <= data[ATT_W-1:0];
        end
        assign pre_att[ch] = q;
    end

    // Converter settings register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         dac_r <= '0;
        else if (pwdn_wr)                   dac_r <= DAC_PWDN;
        else if (wr && addr == ADDR_DAC)    dac_r <= data[DAC_W-1:0];
    end

    // Serial-format settings register, reserved bit kept at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ifc_r <= '0;
        else if (pwdn_wr)                   ifc_r <= '0;
        else if (wr && addr == ADDR_IFC)    ifc_r <= data[IFC_W-1:0] & IFC_MASK;
    end

    assign shadow = '{att_l: pre_att[A_LEFT], att_r: pre_att[A_RIGHT],
                      dac: dac_r, ifc: ifc_r, upd_tgl: 1'b0};

    // Pending-change and pending-update flags, cleared by a launch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty    <= 1'b0;
            upd_pend <= 1'b0;
        end else begin
            dirty    <= wr      || (dirty    && !launch);
            upd_pend <= upd_req || (upd_pend && !launch);
        end
    end

    // Snapshot holding register and request toggle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap    <= '{att_l: ATT_RESET, att_r: ATT_RESET, dac: '0,
                         ifc: '0, upd_tgl: 1'b0};
            req_tgl <= 1'b0;
        end else if (launch) begin
            snap    <= '{att_l: pre_att[A_LEFT], att_r: pre_att[A_RIGHT],
                         dac: dac_r, ifc: ifc_r,
                         upd_tgl: snap.upd_tgl ^ upd_pend};
            req_tgl <= ~req_tgl;
        end
    end
endmodule

// File: rtl/ctl3w_adom.sv
// Audio-domain receiver. It synchronises the request toggle, takes the
// snapshot bus when the toggle changes, returns the toggle as acknowledge,
// and applies the volume codes with a one-cycle pulse when the snapshot's
// update toggle differs from the last one seen. Assumes the snapshot bus is
// held stable from launch until the acknowledge returns.
module ctl3w_adom
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    input  cfg_snap_t        snap,
    output logic             ack_tgl,
    output logic [ATT_W-1:0] att_l,
    output logic [ATT_W-1:0] att_r,
    output logic             att_upd,
    output logic [DAC_W-1:0] dac_cfg,
    output logic [IFC_W-1:0] ifc_cfg
);
    logic req_s, req_seen, upd_seen, take;

    ctl3w_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    assign take    = req_s ^ req_seen;
    assign ack_tgl = req_seen;

    // Snapshot capture and volume application.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            upd_seen <= 1'b0;
            att_l    <= ATT_RESET;
            att_r    <= ATT_RESET;
            att_upd  <= 1'b0;
            dac_cfg  <= '0;
            ifc_cfg  <= '0;
        end else begin
            att_upd <= 1'b0;
            if (take) begin
                req_seen <= req_s;
                dac_cfg  <= snap.dac;
                ifc_cfg  <= snap.ifc;
                if (snap.upd_tgl != upd_seen) begin
                    upd_seen <= snap.upd_tgl;
                    att_l    <= snap.att_l;
                    att_r    <= snap.att_r;
                    att_upd  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ctl3w_top.sv
// Three-wire write-only control port with resynchronised register outputs.
// Control logic runs on cclk, outputs on aclk; the two clocks may be fully
// unrelated. Assumes both resets are asserted together at start-up.
module ctl3w_top
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             cclk,
    input  logic             crst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_latch,
    input  logic             aclk,
    input  logic             arst_n,
    output logic [ATT_W-1:0] att_l,
    output logic [ATT_W-1:0] att_r,
    output logic             att_upd,
    output logic [DAC_W-1:0] dac_cfg,
    output logic [IFC_W-1:0] ifc_cfg
);
    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    cfg_snap_t          shadow;
    cfg_snap_t          snap;
    logic               req_tgl, ack_tgl, ack_s;

    ctl3w_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk       (cclk),
        .rst_n     (crst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_latch (ser_latch),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    ctl3w_regs u_regs (
        .clk       (cclk),
        .rst_n     (crst_n),
        .frame_vld (frame_vld),
        .frame     (frame),
        .ack_s     (ack_s),
        .shadow    (shadow),
        .snap      (snap),
        .req_tgl   (req_tgl)
    );

    ctl3w_sync #(.W(1), .STAGES(SYNC_STAGES)) u_async (
        .clk   (cclk),
        .rst_n (crst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    ctl3w_adom #(.SYNC_STAGES(SYNC_STAGES)) u_adom (
        .clk     (aclk),
        .rst_n   (arst_n),
        .req_tgl (req_tgl),
        .snap    (snap),
        .ack_tgl (ack_tgl),
        .att_l   (att_l),
        .att_r   (att_r),
        .att_upd (att_upd),
        .dac_cfg (dac_cfg),
        .ifc_cfg (ifc_cfg)
    );
endmodule

// File: rtl/ctl3w_chk.sv
// Checker for ctl3w_top: relates committed frames to register state on the
// control side, the snapshot bus to the handshake, and the volume outputs to
// the update pulse on the audio side. Attached by the bind below.
module ctl3w_chk
    import ctl3w_pkg::*;
(
    input logic               cclk,
    input logic               crst_n,
    input logic               aclk,
    input logic               arst_n,
    input logic               frame_vld,
    input logic [FRAME_W-1:0] frame,
    input cfg_snap_t          shadow,
    input cfg_snap_t          snap,
    input logic               req_tgl,
    input logic               ack_s,
    input logic [ATT_W-1:0]   att_l,
    input logic [ATT_W-1:0]   att_r,
    input logic               att_upd
);
    a_r4_bad_addr_ignored: assert property (@(posedge cclk) disable iff (!crst_n)
        (frame_vld && frame[FRAME_W-1 -: ADDR_W] > ADDR_W'(NUM_REGS - 1))
        |=> $stable(shadow));

    a_r9_pwdn_defaults: assert property (@(posedge cclk) disable iff (!crst_n)
        (frame_vld && frame[FRAME_W-1 -: ADDR_W] == ADDR_W'(A_DAC) && frame[PWDN_BIT])
        |=> (shadow.att_l == ATT_RESET && shadow.att_r == ATT_RESET &&
             shadow.dac == (DAC_W'(1) << PWDN_BIT) && shadow.ifc == '0));

    a_r10_snapshot_held: assert property (@(posedge cclk) disable iff (!crst_n)
        ((req_tgl != ack_s) && $past(req_tgl != ack_s)) |-> $stable(snap));

    a_r6_upd_single_cycle: assert property (@(posedge aclk) disable iff (!arst_n)
        att_upd |=> !att_upd);

    a_r5_att_moves_with_upd: assert property (@(posedge aclk) disable iff (!arst_n)
        (!$stable(att_l) || !$stable(att_r)) |-> att_upd);
endmodule

bind ctl3w_top ctl3w_chk u_chk (
    .cclk      (cclk),
    .crst_n    (crst_n),
    .aclk      (aclk),
    .arst_n    (arst_n),
    .frame_vld (frame_vld),
    .frame     (frame),
    .shadow    (shadow),
    .snap      (snap),
    .req_tgl   (req_tgl),
    .ack_s     (ack_s),
    .att_l     (att_l),
    .att_r     (att_r),
    .att_upd   (att_upd)
);

// File: tb/test_ctl3w_top.sv
`timescale 1ns/1ps
module test_ctl3w_top;
    logic       cclk = 1'b0;
    logic       aclk = 1'b0;
    logic       crst_n = 1'b0;
    logic       arst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_latch = 1'b0;
    logic [7:0] att_l, att_r;
    logic       att_upd;
    logic [5:0] dac_cfg;
    logic [8:0] ifc_cfg;

    int n_chk = 0;
    int n_bad = 0;
    int upd_cnt = 0;
    int a_half = 13;

    always #10 cclk = ~cclk;                 // 50 MHz control clock
    always #(a_half * 1ns) aclk = ~aclk;     // audio clock, slowed in one test

    ctl3w_top i_ctl3w_top (
        .cclk(cclk), .crst_n(crst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .aclk(aclk), .arst_n(arst_n),
        .att_l(att_l), .att_r(att_r), .att_upd(att_upd),
        .dac_cfg(dac_cfg), .ifc_cfg(ifc_cfg)
    );

    // Count high cycles of the update pulse away from the active edge.
    always @(negedge aclk) if (arst_n && att_upd) upd_cnt++;

    // Vector: frame, exp att_l, exp att_r, exp dac_cfg, exp ifc_cfg, exp pulses.
    localparam int NV = 11;
    localparam logic [48:0] VEC [NV] = '{
        {16'h0040, 8'hFF, 8'hFF, 6'h00, 9'h000, 2'd0},  // R5 left pre-latch only
        {16'h0280, 8'hFF, 8'hFF, 6'h00, 9'h000, 2'd0},  // R5 right pre-latch only
        {16'h0130, 8'h30, 8'h80, 6'h00, 9'h000, 2'd1},  // R6 update applies both
        {16'h042B, 8'h30, 8'h80, 6'h2B, 9'h000, 2'd0},  // R7 settings
        {16'h07FF, 8'h30, 8'h80, 6'h2B, 9'h1F7, 2'd0},  // R8 bit 3 forced 0
        {16'h0A00, 8'h30, 8'h80, 6'h2B, 9'h1F7, 2'd0},  // R4 address 5
        {16'h0300, 8'h30, 8'h00, 6'h2B, 9'h1F7, 2'd1},  // R6 right update, code 0
        {16'h0642, 8'h30, 8'h00, 6'h2B, 9'h042, 2'd0},  // R8 rate + polarity
        {16'hFFFF, 8'h30, 8'h00, 6'h2B, 9'h042, 2'd0},  // R4 address 127
        {16'h043F, 8'hFF, 8'hFF, 6'h04, 9'h000, 2'd1},  // R9 power-down clears
        {16'h0400, 8'hFF, 8'hFF, 6'h00, 9'h000, 2'd0}   // R7 power-down released
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge cclk);
    endtask

    // Shift n bits of v, MSB first (R2).
    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            wait_c(4);
            ser_clk = 1'b1;
            wait_c(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic latch();
        wait_c(4);
        ser_latch = 1'b1;
        wait_c(4);
        ser_latch = 1'b0;
        wait_c(4);
    endtask

    task automatic settle();
        repeat (12) @(negedge aclk);
        wait_c(10);
    endtask

    task automatic write_frame(input logic [15:0] f);
        send_bits({16'h0, f}, 16);
        latch();
    endtask

    initial begin
        #4ms;
        n_bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        wait_c(5);
        crst_n = 1'b1;
        arst_n = 1'b1;
        settle();

        // R1 reset state
        chk("R1", "att_l", att_l, 8'hFF);
        chk("R1", "att_r", att_r, 8'hFF);
        chk("R1", "dac_cfg", dac_cfg, 0);
        chk("R1", "ifc_cfg", ifc_cfg, 0);
        chk("R1", "att_upd count", upd_cnt, 0);

        // Table walk (R2 frame format exercised by every entry)
        for (int k = 0; k < NV; k++) begin
            base = upd_cnt;
            write_frame(VEC[k][48:33]);
            settle();
            chk("R6", $sformatf("vec%0d att_l", k), att_l, VEC[k][32:25]);
            chk("R6", $sformatf("vec%0d att_r", k), att_r, VEC[k][24:17]);
            chk("R7", $sformatf("vec%0d dac_cfg", k), dac_cfg, VEC[k][16:11]);
            chk("R8", $sformatf("vec%0d ifc_cfg", k), ifc_cfg, VEC[k][10:2]);
            chk("R6", $sformatf("vec%0d pulses", k), upd_cnt - base, VEC[k][1:0]);
        end

        // R3 short frame: 12 bits of a left update frame, must be dropped
        base = upd_cnt;
        send_bits(32'h000001AA, 12);
        latch();
        settle();
        chk("R3", "short att_l", att_l, 8'hFF);
        chk("R3", "short pulses", upd_cnt - base, 0);

        // R3 long frame: 20 bits, last 16 are a left update to 0x55
        base = upd_cnt;
        send_bits(32'h000F0155, 20);
        latch();
        settle();
        chk("R3", "long att_l", att_l, 8'h55);
        chk("R3", "long att_r", att_r, 8'hFF);
        chk("R2", "long pulses", upd_cnt - base, 1);

        // R5 pre-latch without update leaves outputs alone
        write_frame(16'h0077);
        settle();
        chk("R5", "pre-latch att_l", att_l, 8'h55);

        // R10 merged writes while a transfer is slowed down
        a_half = 2000;
        repeat (2) @(negedge aclk);
        base = upd_cnt;
        write_frame(16'h0111);
        write_frame(16'h0222);
        write_frame(16'h0344);
        write_frame(16'h0401);
        settle();
        chk("R10", "merged att_l", att_l, 8'h11);
        chk("R10", "merged att_r", att_r, 8'h44);
        chk("R10", "merged dac_cfg", dac_cfg, 6'h01);
        chk("R10", "merged pulses ok", ((upd_cnt - base) >= 1 && (upd_cnt - base) <= 2), 1);
        a_half = 13;
        settle();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule